// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block sits behind the frame parser of an Ethernet receiver. It decides, for each frame, whether the destination address is wanted. When a frame is wanted, it also chooses the receive channel that the frame goes to. The parser presents the 48-bit destination address and the frame length in parallel for one cycle. The filter answers one cycle later with a valid pulse, an accept flag and a channel number.

The filter is configured through a small word-addressed register port. The port holds:
- a mode word with enable bits and channel steering fields;
- a programmable maximum frame length;
- a 64-bit multicast hash table split into two words;
- the station address: bytes 0 to 3 in one word, byte 4 in another, and byte 5 once per channel;
- an 8-bit per-channel unicast enable mask, changed through separate set and clear words.

Promiscuous mode accepts everything. Broadcast and multicast frames are steered to their own channels. Unicast frames go to the lowest enabled channel whose full station address matches.

Top module: `arf_filter`

## Requirements
- R1: After reset, dec_valid and dec_accept are 0. Read back, the mode word is 0, both hash words are 0, the unicast mask is 0 and the maximum length is 1522.
- R2: Register map, by word address. 0 is the mode word. 1 is unicast set: write 1s to set mask bits, and a read returns the mask. 2 is unicast clear: write 1s to clear mask bits. 3 is the maximum length (low 16 bits). 4 is hash bits 31:0. 5 is hash bits 63:32. 6 holds station bytes 0..3, byte 0 in bits 7:0 and byte 3 in bits 31:24. 7 holds station byte 4 in bits 7:0. 8+c holds station byte 5 for channel c. cfg_rd_data shows the word addressed by cfg_rd_addr one cycle later.
- R3: A set write ORs its low 8 bits into the unicast mask. A clear write removes the bits that are 1. Bits written as 0 leave the mask unchanged.
- R4: Address byte 0 is rx_dst[47:40] and byte 5 is rx_dst[7:0]. A unicast frame is one whose byte 0 bit 0 is 0. It is accepted when some channel c has its mask bit set, bytes 0..4 equal the shared station bytes, and byte 5 equals channel c's byte. The reported channel is the lowest such c.
- R5: An all-ones destination is broadcast. It is accepted only when mode bit 13 is set, and it is steered to the channel in mode bits 10:8. It never takes the multicast path.
- R6: A non-broadcast address with byte 0 bit 0 set is multicast. Its hash index is the low 6 bits of an XOR over six byte terms: (b>>2)^(b<<4) for bytes 0 and 3, (b>>4)^(b<<2) for bytes 1 and 4, and (b>>6)^b for bytes 2 and 5. The frame is accepted when mode bit 5 is set and that hash bit is 1 (indices 0–31 in the low word, 32–63 in the high word). It is steered to mode bits 2:0.
- R7: With both hash words all ones and mode bit 5 set, every multicast address is accepted.
- R8: With mode bit 21 set, every frame is accepted on the channel in mode bits 18:16. This overrides the address, length and enable checks.
- R9: Outside promiscuous mode, a frame longer than the maximum length is dropped. A frame of exactly the maximum length passes the length check.
- R10: Outside promiscuous mode, a frame shorter than 64 bytes is dropped unless mode bit 23 is set.
- R11: A frame presented with rx_valid in cycle t gives dec_valid high in cycle t+1 only. A dropped frame reports channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 4 | Register write word address |
| cfg_wr_data | input | 32 | Register write data |
| cfg_rd_addr | input | 4 | Register read word address |
| cfg_rd_data | output | 32 | Registered read data |
| rx_valid | input | 1 | Destination and length are valid this cycle |
| rx_dst | input | 48 | Destination address, byte 0 in the top byte |
| rx_len | input | 16 | Frame length in bytes |
| dec_valid | output | 1 | Decision valid |
| dec_accept | output | 1 | Frame accepted |
| dec_chan | output | 3 | Receive channel of an accepted frame |

## Verification
The multicast sweep sends several hundred pseudo-random multicast addresses against two complementary hash patterns. A wrong shift direction, a wrong byte-to-term pairing or a missed truncation would accept about half of these frames wrongly.

The length sweep probes 63 and 64 bytes, and the maximum length and one byte past it. An off-by-one comparison fails at exactly one of those points.

The unicast cases give two enabled channels the same final byte, then clear the lower one. A matcher with the wrong priority, or one that ignores the mask, reports the wrong channel.

Promiscuous frames are sent with bad addresses and illegal lengths. A design that applied the length check first would drop them. Broadcast frames are sent with the hash table full. A design that let broadcast fall into the multicast path would accept them while broadcast is disabled.

// File: rtl/arf_pkg.sv
package arf_pkg;

    // Mode word bit positions (decoded by the filter core)
    localparam int MB_SHORT_OK   = 23;
    localparam int MB_PROM_EN    = 21;
    localparam int MB_PROM_CH    = 16;
    localparam int MB_BCAST_EN   = 13;
    localparam int MB_BCAST_CH   = 8;
    localparam int MB_MCAST_EN   = 5;
    localparam int MB_MCAST_CH   = 0;

    localparam int REG_AW        = 4;
    localparam int STEER_W       = 3;

    typedef enum logic [REG_AW-1:0] {
        RA_MODE    = 4'd0,
        RA_UC_SET  = 4'd1,
        RA_UC_CLR  = 4'd2,
        RA_MAXLEN  = 4'd3,
        RA_HASH_LO = 4'd4,
        RA_HASH_HI = 4'd5,
        RA_STA_HI  = 4'd6,
        RA_STA_MID = 4'd7
    } reg_addr_e;

    localparam logic [REG_AW-1:0] RA_STA_LO_BASE = 4'd8;

    typedef struct packed {
        logic               short_ok;
        logic               prom_en;
        logic [STEER_W-1:0] prom_ch;
        logic               bc_en;
        logic [STEER_W-1:0] bc_ch;
        logic               mc_en;
        logic [STEER_W-1:0] mc_ch;
    } mode_t;

    function automatic mode_t decode_mode(input logic [31:0] w);
        mode_t m;
        m.short_ok = w[MB_SHORT_OK];
        m.prom_en  = w[MB_PROM_EN];
        m.prom_ch  = w[MB_PROM_CH +: STEER_W];
        m.bc_en    = w[MB_BCAST_EN];
        m.bc_ch    = w[MB_BCAST_CH +: STEER_W];
        m.mc_en    = w[MB_MCAST_EN];
        m.mc_ch    = w[MB_MCAST_CH +: STEER_W];
        return m;
    endfunction

endpackage

// File: rtl/arf_regs.sv
module arf_regs
    import arf_pkg::*;
#(
    parameter int NUM_CH     = 8,
    parameter int LEN_W      = 16,
    parameter int MAXLEN_RST = 1522
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [REG_AW-1:0]        wr_addr,
    input  logic [31:0]              wr_data,
    input  logic [REG_AW-1:0]        rd_addr,
    output logic [31:0]              rd_data,
    output mode_t                    mode,
    output logic [63:0]              hash_tbl,
    output logic [31:0]              sta_hi,
    output logic [7:0]               sta_mid,
    output logic [NUM_CH-1:0][7:0]   sta_lo,
    output logic [NUM_CH-1:0]        uc_en,
    output logic [LEN_W-1:0]         max_len
);

    typedef struct packed {
        logic [31:0]            mode_w;
        logic [63:0]            hash;
        logic [31:0]            sta_hi;
        logic [7:0]             sta_mid;
        logic [NUM_CH-1:0][7:0] sta_lo;
        logic [NUM_CH-1:0]      uc_en;
        logic [LEN_W-1:0]       max_len;
        logic [31:0]            rd_data;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            unique case (wr_addr)
                RA_MODE:    r_d.mode_w        = wr_data;
                RA_UC_SET:  r_d.uc_en         = r_q.uc_en | wr_data[NUM_CH-1:0];
                RA_UC_CLR:  r_d.uc_en         = r_q.uc_en & ~wr_data[NUM_CH-1:0];
                RA_MAXLEN:  r_d.max_len       = wr_data[LEN_W-1:0];
                RA_HASH_LO: r_d.hash[31:0]    = wr_data;
                RA_HASH_HI: r_d.hash[63:32]   = wr_data;
                RA_STA_HI:  r_d.sta_hi        = wr_data;
                RA_STA_MID: r_d.sta_mid       = wr_data[7:0];
                default: begin
                    for (int c = 0; c < NUM_CH; c++) begin
                        if (wr_addr == RA_STA_LO_BASE + REG_AW'(c))
                            r_d.sta_lo[c] = wr_data[7:0];
                    end
                end
            endcase
        end

        unique case (rd_addr)
            RA_MODE:    r_d.rd_data = r_q.mode_w;
            RA_UC_SET:  r_d.rd_data = 32'(r_q.uc_en);
            RA_UC_CLR:  r_d.rd_data = 32'(r_q.uc_en);
            RA_MAXLEN:  r_d.rd_data = 32'(r_q.max_len);
            RA_HASH_LO: r_d.rd_data = r_q.hash[31:0];
            RA_HASH_HI: r_d.rd_data = r_q.hash[63:32];
            RA_STA_HI:  r_d.rd_data = r_q.sta_hi;
            RA_STA_MID: r_d.rd_data = 32'(r_q.sta_mid);
            default: begin
                r_d.rd_data = '0;
                for (int c = 0; c < NUM_CH; c++) begin
                    if (rd_addr == RA_STA_LO_BASE + REG_AW'(c))
                        r_d.rd_data = 32'(r_q.sta_lo[c]);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.max_len <= LEN_W'(MAXLEN_RST);
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_data  = r_q.rd_data;
    assign mode     = decode_mode(r_q.mode_w);
    assign hash_tbl = r_q.hash;
    assign sta_hi   = r_q.sta_hi;
    assign sta_mid  = r_q.sta_mid;
    assign sta_lo   = r_q.sta_lo;
    assign uc_en    = r_q.uc_en;
    assign max_len  = r_q.max_len;

    // R3: clear write removes every bit written as 1
    a_r3_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RA_UC_CLR) |=> ((uc_en & $past(wr_data[NUM_CH-1:0])) == '0));

    // R3: set write keeps every bit written as 1
    a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RA_UC_SET) |=> ((uc_en & $past(wr_data[NUM_CH-1:0])) == $past(wr_data[NUM_CH-1:0])));

endmodule

// File: rtl/arf_hash.sv
module arf_hash (
    input  logic [47:0] dst,
    output logic [5:0]  idx
);

    logic [5:0] term [6];

    for (genvar i = 0; i < 6; i++) begin : g_term
        logic [7:0] b;
        assign b = dst[47-8*i -: 8];
        if (i % 3 == 0) begin : g_s24
            assign term[i] = b[7:2] ^ {b[1:0], 4'b0000};
        end else if (i % 3 == 1) begin : g_s42
            assign term[i] = {2'b00, b[7:4]} ^ {b[3:0], 2'b00};
        end else begin : g_s60
            assign term[i] = {4'b0000, b[7:6]} ^ b[5:0];
        end
    end

    assign idx = term[0] ^ term[1] ^ term[2] ^ term[3] ^ term[4] ^ term[5];

endmodule

// File: rtl/arf_ucast.sv
module arf_ucast #(
    parameter int NUM_CH = 8,
    parameter int CH_W   = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [47:0]            dst,
    input  logic [31:0]            sta_hi,
    input  logic [7:0]             sta_mid,
    input  logic [NUM_CH-1:0][7:0] sta_lo,
    input  logic [NUM_CH-1:0]      uc_en,
    output logic                   hit,
    output logic [CH_W-1:0]        ch
);

    logic             upper_ok;
    logic [NUM_CH-1:0] match;

    // station bytes 0..3 are packed little-endian in sta_hi
    assign upper_ok = (dst[47:40] == sta_hi[7:0])   &&
                      (dst[39:32] == sta_hi[15:8])  &&
                      (dst[31:24] == sta_hi[23:16]) &&
                      (dst[23:16] == sta_hi[31:24]) &&
                      (dst[15:8]  == sta_mid);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        assign match[c] = uc_en[c] && upper_ok && (dst[7:0] == sta_lo[c]);
    end

    always_comb begin
        hit = 1'b0;
        ch  = '0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (match[c]) begin
                hit = 1'b1;
                ch  = CH_W'(c);
            end
        end
    end

    // R4: a reported channel is always one that is enabled
    a_r4_hit_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> uc_en[ch]);

endmodule

// File: rtl/arf_filter.sv
module arf_filter
    import arf_pkg::*;
#(
    parameter int NUM_CH     = 8,
    parameter int LEN_W      = 16,
    parameter int MIN_LEN    = 64,
    parameter int MAXLEN_RST = 1522
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [REG_AW-1:0] cfg_wr_addr,
    input  logic [31:0]       cfg_wr_data,
    input  logic [REG_AW-1:0] cfg_rd_addr,
    output logic [31:0]       cfg_rd_data,
    input  logic              rx_valid,
    input  logic [47:0]       rx_dst,
    input  logic [LEN_W-1:0]  rx_len,
    output logic              dec_valid,
    output logic              dec_accept,
    output logic [STEER_W-1:0] dec_chan
);

    localparam int CH_W = STEER_W;

    mode_t                  mode;
    logic [63:0]            hash_tbl;
    logic [31:0]            sta_hi;
    logic [7:0]             sta_mid;
    logic [NUM_CH-1:0][7:0] sta_lo;
    logic [NUM_CH-1:0]      uc_en;
    logic [LEN_W-1:0]       max_len;
    logic [5:0]             hidx;
    logic                   uc_hit;
    logic [CH_W-1:0]        uc_ch;

    arf_regs #(.NUM_CH(NUM_CH), .LEN_W(LEN_W), .MAXLEN_RST(MAXLEN_RST)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr), .wr_data(cfg_wr_data),
        .rd_addr(cfg_rd_addr), .rd_data(cfg_rd_data),
        .mode(mode), .hash_tbl(hash_tbl), .sta_hi(sta_hi), .sta_mid(sta_mid),
        .sta_lo(sta_lo), .uc_en(uc_en), .max_len(max_len)
    );

    arf_hash u_hash (.dst(rx_dst), .idx(hidx));

    arf_ucast #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_ucast (
        .clk(clk), .rst_n(rst_n), .dst(rx_dst),
        .sta_hi(sta_hi), .sta_mid(sta_mid), .sta_lo(sta_lo), .uc_en(uc_en),
        .hit(uc_hit), .ch(uc_ch)
    );

    typedef struct packed {
        logic            valid;
        logic            accept;
        logic [CH_W-1:0] chan;
    } dec_t;

    dec_t s_d, s_q;
    logic is_bc, is_mc, too_long, too_short;

    always_comb begin
        is_bc     = &rx_dst;
        is_mc     = rx_dst[40] && !is_bc;
        too_long  = rx_len > max_len;
        too_short = (rx_len < LEN_W'(MIN_LEN)) && !mode.short_ok;

        s_d       = '0;
        s_d.valid = rx_valid;
        if (rx_valid) begin
            if (mode.prom_en) begin
                s_d.accept = 1'b1;
                s_d.chan   = mode.prom_ch;
            end else if (!too_long && !too_short) begin
                if (is_bc) begin
                    if (mode.bc_en) begin
                        s_d.accept = 1'b1;
                        s_d.chan   = mode.bc_ch;
                    end
                end else if (is_mc) begin
                    if (mode.mc_en && hash_tbl[hidx]) begin
                        s_d.accept = 1'b1;
                        s_d.chan   = mode.mc_ch;
                    end
                end else if (uc_hit) begin
                    s_d.accept = 1'b1;
                    s_d.chan   = uc_ch;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dec_valid  = s_q.valid;
    assign dec_accept = s_q.accept;
    assign dec_chan   = s_q.chan;

    // R11: one decision per presented frame, one cycle later
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> dec_valid);
    a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> !dec_valid);
    a_r11_drop_chan_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_accept) |-> dec_chan == '0);

    // R8: promiscuous overrides everything
    a_r8_prom_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && mode.prom_en) |=> (dec_accept && dec_chan == $past(mode.prom_ch)));

    // R9: over-length frames are dropped
    a_r9_long_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !mode.prom_en && rx_len > max_len) |=> !dec_accept);

    // R10: runt frames are dropped unless allowed
    a_r10_short_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !mode.prom_en && !mode.short_ok && rx_len < LEN_W'(MIN_LEN)) |=> !dec_accept);

    // R5: broadcast disabled means dropped, whatever the hash table holds
    a_r5_bcast_off: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !mode.prom_en && (&rx_dst) && !mode.bc_en) |=> !dec_accept);

    // R6: multicast disabled means dropped
    a_r6_mcast_off: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !mode.prom_en && rx_dst[40] && !(&rx_dst) && !mode.mc_en) |=> !dec_accept);

endmodule

// File: tb/tb_arf_filter.sv
`timescale 1ns/1ps
module tb_arf_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [3:0]  cfg_wr_addr = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [3:0]  cfg_rd_addr = '0;
    logic [31:0] cfg_rd_data;
    logic        rx_valid = 1'b0;
    logic [47:0] rx_dst = '0;
    logic [15:0] rx_len = '0;
    logic        dec_valid, dec_accept;
    logic [2:0]  dec_chan;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    arf_filter dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data),
        .rx_valid(rx_valid), .rx_dst(rx_dst), .rx_len(rx_len),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_chan(dec_chan)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_rd_addr = a;
        @(posedge clk);
        #1 d = cfg_rd_data;
    endtask

    // returns {valid, accept, chan}
    task automatic frame(input logic [47:0] a, input logic [15:0] len, output logic [4:0] res);
        @(negedge clk);
        rx_valid = 1'b1; rx_dst = a; rx_len = len;
        @(posedge clk);
        #1 res = {dec_valid, dec_accept, dec_chan};
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    function automatic logic [31:0] mk_mode(bit s, bit p, int pc, bit b, int bc, bit m, int mc);
        return (32'(s) << 23) | (32'(p) << 21) | (32'(pc & 7) << 16) |
               (32'(b) << 13) | (32'(bc & 7) << 8) | (32'(m) << 5) | 32'(mc & 7);
    endfunction

    function automatic int ref_hash(logic [47:0] a);
        int h = 0;
        for (int i = 0; i < 6; i++) begin
            int b = int'(a[47-8*i -: 8]);
            case (i % 3)
                0: h = h ^ ((b >> 2) ^ (b << 4));
                1: h = h ^ ((b >> 4) ^ (b << 2));
                default: h = h ^ ((b >> 6) ^ b);
            endcase
        end
        return h % 64;
    endfunction

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    localparam logic [39:0] STA_UP = 40'h02_11_22_33_44;
    localparam logic [63:0] PAT    = 64'h0F1E_2D3C_4B5A_6978;

    initial begin
        logic [31:0] d;
        logic [4:0]  r;
        logic [31:0] seed = 32'h1234_5678;

        repeat (3) @(posedge clk);
        #1;
        chk("R1 dec_valid", dec_valid, 0);
        chk("R1 dec_accept", dec_accept, 0);
        @(negedge clk) rst_n = 1'b1;

        rd(4'd0, d); chk("R1 mode", d, 0);
        rd(4'd3, d); chk("R1 maxlen", d, 1522);
        rd(4'd4, d); chk("R1 hash lo", d, 0);
        rd(4'd5, d); chk("R1 hash hi", d, 0);
        rd(4'd1, d); chk("R1 uc mask", d, 0);

        // R2 readback
        wr(4'd4, 32'hDEAD_BEEF); rd(4'd4, d); chk("R2 hash lo", d, 32'hDEAD_BEEF);
        wr(4'd6, 32'h3322_1102); rd(4'd6, d); chk("R2 sta hi", d, 32'h3322_1102);
        wr(4'd7, 32'h44);        rd(4'd7, d); chk("R2 sta mid", d, 32'h44);
        for (int c = 0; c < 8; c++) wr(4'(8 + c), 32'(8'h50 + c));
        for (int c = 0; c < 8; c++) begin
            rd(4'(8 + c), d); chk("R2 sta lo", d, 32'(8'h50 + c));
        end

        // R3 set/clear
        wr(4'd1, 32'hA5); rd(4'd1, d); chk("R3 set", d, 32'hA5);
        wr(4'd2, 32'h21); rd(4'd1, d); chk("R3 clear", d, 32'h84);
        wr(4'd1, 32'h00); rd(4'd2, d); chk("R3 set zero", d, 32'h84);
        wr(4'd1, 32'hFF); rd(4'd1, d); chk("R3 set all", d, 32'hFF);

        // R4 unicast on each channel
        for (int c = 0; c < 8; c++) begin
            frame({STA_UP, 8'(8'h50 + c)}, 16'd100, r);
            chk("R4 uc chan", r, {2'b11, 3'(c)});
        end
        wr(4'd10, 32'h77); wr(4'd13, 32'h77);
        frame({STA_UP, 8'h77}, 16'd100, r); chk("R4 lowest chan", r, {2'b11, 3'd2});
        wr(4'd2, 32'h04);
        frame({STA_UP, 8'h77}, 16'd100, r); chk("R4 after clear", r, {2'b11, 3'd5});
        frame({STA_UP ^ 40'h00_01_00_00_00, 8'h50}, 16'd100, r); chk("R4 mismatch", r, 5'b10000);
        frame({STA_UP ^ 40'h00_00_00_00_80, 8'h50}, 16'd100, r); chk("R4 byte4 mismatch", r, 5'b10000);
        wr(4'd2, 32'hFF);
        frame({STA_UP, 8'h50}, 16'd100, r); chk("R4 disabled", r, 5'b10000);
        // R11: no pulse when idle
        @(posedge clk); #1 chk("R11 idle", dec_valid, 0);
        wr(4'd1, 32'h01);

        // R9 default maximum
        frame({STA_UP, 8'h50}, 16'd1522, r); chk("R9 at max", r, 5'b11000);
        frame({STA_UP, 8'h50}, 16'd1523, r); chk("R9 over max", r, 5'b10000);
        wr(4'd3, 32'd100);
        frame({STA_UP, 8'h50}, 16'd100, r); chk("R9 at prog max", r, 5'b11000);
        frame({STA_UP, 8'h50}, 16'd101, r); chk("R9 over prog max", r, 5'b10000);
        wr(4'd3, 32'd1522);

        // R10 short frames
        frame({STA_UP, 8'h50}, 16'd63, r); chk("R10 63", r, 5'b10000);
        frame({STA_UP, 8'h50}, 16'd64, r); chk("R10 64", r, 5'b11000);
        wr(4'd0, mk_mode(1, 0, 0, 0, 0, 0, 0));
        frame({STA_UP, 8'h50}, 16'd63, r); chk("R10 63 allowed", r, 5'b11000);
        frame({STA_UP, 8'h50}, 16'd1, r);  chk("R10 1 allowed", r, 5'b11000);

        // R5 broadcast (hash full, multicast on: must not leak)
        wr(4'd4, 32'hFFFF_FFFF); wr(4'd5, 32'hFFFF_FFFF);
        wr(4'd0, mk_mode(0, 0, 0, 0, 6, 1, 3));
        frame(48'hFFFF_FFFF_FFFF, 16'd64, r); chk("R5 bcast off", r, 5'b10000);
        wr(4'd0, mk_mode(0, 0, 0, 1, 6, 1, 3));
        frame(48'hFFFF_FFFF_FFFF, 16'd64, r); chk("R5 bcast on", r, {2'b11, 3'd6});

        // R7 all-ones hash accepts every multicast
        for (int i = 0; i < 64; i++) begin
            logic [47:0] a;
            seed = seed * 32'd1103515245 + 32'd12345;
            a = {seed, 16'(seed >> 7)};
            a[40] = 1'b1; a[0] = 1'b0;
            frame(a, 16'd200, r); chk("R7 all multicast", r, {2'b11, 3'd3});
        end

        // R6 hash sweep with a pattern and its complement
        for (int p = 0; p < 2; p++) begin
            logic [63:0] pat = (p == 0) ? PAT : ~PAT;
            wr(4'd4, pat[31:0]); wr(4'd5, pat[63:32]);
            for (int i = 0; i < 300; i++) begin
                logic [47:0] a;
                int h;
                seed = seed * 32'd1103515245 + 32'd12345;
                a[47:24] = seed[31:8];
                seed = seed * 32'd1103515245 + 32'd12345;
                a[23:0] = seed[31:8];
                a[40] = 1'b1; a[0] = 1'b0;
                h = ref_hash(a);
                frame(a, 16'd128, r);
                chk("R6 hash", r, pat[h] ? {2'b11, 3'd3} : 5'b10000);
            end
        end
        wr(4'd0, mk_mode(0, 0, 0, 1, 6, 0, 3));
        wr(4'd4, 32'hFFFF_FFFF); wr(4'd5, 32'hFFFF_FFFF);
        frame(48'h01_00_5E_00_00_01, 16'd128, r); chk("R6 mcast off", r, 5'b10000);

        // R8 promiscuous overrides
        wr(4'd0, mk_mode(0, 1, 5, 0, 0, 0, 0));
        frame(48'h02_99_99_99_99_99, 16'd100, r); chk("R8 foreign uc", r, {2'b11, 3'd5});
        frame(48'h02_99_99_99_99_99, 16'd9000, r); chk("R8 long", r, {2'b11, 3'd5});
        frame(48'h02_99_99_99_99_99, 16'd10, r); chk("R8 short", r, {2'b11, 3'd5});
        frame(48'hFFFF_FFFF_FFFF, 16'd64, r); chk("R8 bcast", r, {2'b11, 3'd5});
        frame(48'h01_00_5E_00_00_01, 16'd64, r); chk("R8 mcast", r, {2'b11, 3'd5});

        finish_run();
    end

endmodule